// File: doc/BRIEF.md
# Four-Format Ripple Adder/Subtracter

This combinational block adds, subtracts or negates two W-bit words, with a default width of 4 bits. A 2-bit format select sets how the bits are read: plain unsigned, sign-and-magnitude, ones' complement or two's complement. One output word holds the answer. A single flag reports that the true answer cannot be shown in the chosen format. For unsigned work this flag means out of range, and for the signed formats it means overflow.

The arithmetic comes from a chain of full-adder cells. In each cell, the sum is the parity of its three inputs and the carry is their 2-of-3 majority. A second pass of the chain adds the end-around carry for ones' complement. A separate magnitude chain does the sign-and-magnitude work: it subtracts when the signs differ and then takes a conditional two's negate of the difference, so the smaller magnitude always comes off the larger. The effective carries out of the top two cells are kept as named wires, and the signed overflow rule is their XOR.

Top module: `multirep_addsub`

## Requirements
- R1: The format code `rep` is 0 for unsigned, 1 for sign-and-magnitude, 2 for ones' complement and 3 for two's complement. The operation code `op` is 0 for add, 1 for subtract and 2 for negate. In unsigned add, `result` = (A+B) mod 2^W and `ovf` is the carry out of the top bit.
- R2: In unsigned subtract, `result` = (A−B) mod 2^W and `ovf` is the borrow, so it is set exactly when A < B.
- R3: In two's complement add and subtract, `result` is the true answer mod 2^W. `ovf` is set exactly when the true answer lies outside −2^(W−1)..2^(W−1)−1.
- R4: In two's complement negate, `result` = (NOT A)+1 mod 2^W. `ovf` is set only when A is the most negative code (top bit alone set).
- R5: In ones' complement add, the carry out of the top bit is added back in at bit 0, so `result` = A+B when that sum is below 2^W and A+B−2^W+1 otherwise.
- R6: Ones' complement subtract is an add of NOT B. In both add and subtract, `ovf` is set exactly when the true value lies outside ±(2^(W−1)−1). Both 0 and all-ones are read as zero.
- R7: In ones' complement negate, `result` = NOT A and `ovf` = 0.
- R8: In sign-and-magnitude, the top bit is the sign (1 = negative) and the rest is the magnitude. When the effective signs match, the magnitudes are added, the sign of A is kept, and `ovf` is the carry out of the magnitude sum.
- R9: In sign-and-magnitude, when the effective signs differ, the smaller magnitude is taken from the larger, the answer carries the sign of the larger, and `ovf` = 0. If the magnitudes are equal, the answer is all zeros (positive zero).
- R10: Sign-and-magnitude subtract flips the sign of B and then follows R8 or R9.
- R11: In sign-and-magnitude negate, only the top bit of A is inverted and `ovf` = 0. This applies to both zero codes as well.
- R12: Operation code 3 gives the same answer and flag as add (code 0) in every format.
- R13: In negate, `op_b` has no effect on `result` or `ovf`. In unsigned negate, `result` = (0−A) mod 2^W and `ovf` = 1 when A ≠ 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand (the one negated in negate) |
| op_b | input | W | Second operand |
| op | input | 2 | Operation: 0 add, 1 subtract, 2 negate, 3 as add |
| rep | input | 2 | Format: 0 unsigned, 1 sign-magnitude, 2 ones', 3 two's |
| result | output | W | Answer word in the selected format |
| ovf | output | 1 | Overflow or out-of-range flag |

## Verification
The block has no state, so any fault shows at the ports while the triggering inputs are still applied, with no latency to wait through. A wrong carry in the chain usually corrupts `result` and `ovf` together. A missing end-around carry shows only in ones' complement sums that carry out of the top bit. A wrong comparison in the magnitude path shows as a flipped sign, or as a negative zero when the magnitudes are equal. The run covers every operand pair for every format and operation code, so each of these paths is hit at once.

// File: rtl/multirep_addsub_pkg.sv
package multirep_addsub_pkg;

  typedef enum logic [1:0] {
    FMT_UNS  = 2'd0,
    FMT_SMAG = 2'd1,
    FMT_ONES = 2'd2,
    FMT_TWOS = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    OPC_ADD = 2'd0,
    OPC_SUB = 2'd1,
    OPC_NEG = 2'd2,
    OPC_ALT = 2'd3
  } opc_e;

  // parity of three inputs
  function automatic logic bit_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // 2-of-3 majority
  function automatic logic bit_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

endpackage

// File: rtl/fa_cell.sv
module fa_cell
  import multirep_addsub_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = bit_sum(x, y, ci);
  assign co = bit_carry(x, y, ci);
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int N = 4
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         ci,
  output logic [N-1:0] s,
  output logic [N-1:0] co
);
  logic [N:0] link;
  assign link[0] = ci;

  for (genvar i = 0; i < N; i++) begin : g_bit
    fa_cell u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (link[i]),
      .s  (s[i]),
      .co (link[i+1])
    );
  end

  assign co = link[N:1];
endmodule

// File: rtl/smag_unit.sv
module smag_unit #(
  parameter int W = 4
) (
  input  logic         sx,
  input  logic         sy,
  input  logic [W-2:0] mx,
  input  logic [W-2:0] my,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int MW = W - 1;

  logic          same_sign;
  logic [MW-1:0] m_sum, m_co, m_flip, f_co, y_in;
  logic          x_ge_y, diff_zero;

  assign same_sign = (sx == sy);
  assign y_in      = same_sign ? my : ~my;

  // add magnitudes, or subtract my from mx when signs differ
  ripple_chain #(.N(MW)) u_mag (
    .x  (mx),
    .y  (y_in),
    .ci (~same_sign),
    .s  (m_sum),
    .co (m_co)
  );

  // two's negate of the difference for the case my > mx
  ripple_chain #(.N(MW)) u_flip (
    .x  (~m_sum),
    .y  ({MW{1'b0}}),
    .ci (1'b1),
    .s  (m_flip),
    .co (f_co)
  );

  assign x_ge_y    = m_co[MW-1];
  assign diff_zero = (m_sum == '0);

  always_comb begin
    ovf = 1'b0;
    if (same_sign) begin
      res = {sx, m_sum};
      ovf = m_co[MW-1];
    end else if (x_ge_y && diff_zero) begin
      res = '0;
    end else if (x_ge_y) begin
      res = {sx, m_sum};
    end else begin
      res = {sy, m_flip};
    end
  end

  logic unused_flip;
  assign unused_flip = ^{f_co, m_co[MW-1:0]};
endmodule

// File: rtl/multirep_addsub.sv
module multirep_addsub
  import multirep_addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   op,
  input  logic [1:0]   rep,
  output logic [W-1:0] result,
  output logic         ovf
);
  localparam int MSB = W - 1;

  fmt_e fmt;
  opc_e opc;
  assign fmt = fmt_e'(rep);
  assign opc = opc_e'(op);

  logic is_neg, do_inv;
  assign is_neg = (opc == OPC_NEG);
  assign do_inv = (opc == OPC_SUB) || is_neg;

  // operand routing: negate is 0 - A
  logic [W-1:0] lhs, rhs, rhs_in;
  assign lhs    = is_neg ? '0 : op_a;
  assign rhs    = is_neg ? op_a : op_b;
  assign rhs_in = do_inv ? ~rhs : rhs;

  // first pass of the main chain
  logic [W-1:0] pass1_s, pass1_c;
  logic         pass1_ci;
  assign pass1_ci = do_inv && (fmt != FMT_ONES);

  ripple_chain #(.N(W)) u_pass1 (
    .x  (lhs),
    .y  (rhs_in),
    .ci (pass1_ci),
    .s  (pass1_s),
    .co (pass1_c)
  );

  // second pass adds the end-around carry (ones' complement only)
  logic         wrap_ci;
  logic [W-1:0] pass2_s, pass2_c;
  assign wrap_ci = (fmt == FMT_ONES) && pass1_c[MSB];

  ripple_chain #(.N(W)) u_pass2 (
    .x  (pass1_s),
    .y  ({W{1'b0}}),
    .ci (wrap_ci),
    .s  (pass2_s),
    .co (pass2_c)
  );

  // effective carries across both passes, brought out for the checker
  logic [W-1:0] car_eff;
  logic         car_top, car_below;
  assign car_eff   = pass1_c | pass2_c;
  assign car_top   = car_eff[MSB];
  assign car_below = car_eff[MSB-1];

  // sign-and-magnitude path
  logic [W-1:0] sm_res;
  logic         sm_ovf;
  smag_unit #(.W(W)) u_smag (
    .sx  (op_a[MSB]),
    .sy  (op_b[MSB] ^ (opc == OPC_SUB)),
    .mx  (op_a[MSB-1:0]),
    .my  (op_b[MSB-1:0]),
    .res (sm_res),
    .ovf (sm_ovf)
  );

  always_comb begin
    result = pass2_s;
    ovf    = 1'b0;
    unique case (fmt)
      FMT_UNS:  ovf = do_inv ? ~pass1_c[MSB] : pass1_c[MSB];
      FMT_ONES,
      FMT_TWOS: ovf = car_top ^ car_below;
      FMT_SMAG: begin
        if (is_neg) begin
          result = {~op_a[MSB], op_a[MSB-1:0]};
        end else begin
          result = sm_res;
          ovf    = sm_ovf;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/multirep_addsub_chk.sv
module multirep_addsub_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [1:0]   op,
  input logic [1:0]   rep,
  input logic [W-1:0] result,
  input logic         ovf,
  input logic         car_top,
  input logic         car_below
);
  logic sgn_b_eff;
  assign sgn_b_eff = op_b[W-1] ^ (op == 2'd1);

  always_comb begin
    if (rep == 2'd0 && (op == 2'd0 || op == 2'd3))
      AST_UNS_CARRY_FLAG: assert (ovf == car_top); // R1
    if (rep == 2'd0 && op == 2'd1)
      AST_UNS_BORROW: assert (ovf == (op_a < op_b)); // R2
    if (rep == 2'd3)
      AST_TWOS_CARRY_XOR: assert (ovf == (car_top ^ car_below)); // R3
    if (rep == 2'd2 && op != 2'd2)
      AST_ONES_CARRY_XOR: assert (ovf == (car_top ^ car_below)); // R6
    if (rep == 2'd2 && op == 2'd2)
      AST_ONES_NEG_INVERT: assert (result == ~op_a && !ovf); // R7
    if (rep == 2'd1 && op != 2'd2 && op_a[W-1] != sgn_b_eff)
      AST_SMAG_MIXED_NO_OVF: assert (!ovf); // R9
    if (rep == 2'd1 && op != 2'd2 && op_a[W-1] != sgn_b_eff && op_a[W-2:0] == op_b[W-2:0])
      AST_SMAG_POS_ZERO: assert (result == '0); // R9
    if (rep == 2'd1 && op == 2'd2)
      AST_SMAG_NEG_SIGN: assert (result == {~op_a[W-1], op_a[W-2:0]} && !ovf); // R11
  end
endmodule

bind multirep_addsub multirep_addsub_chk #(.W(W)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .op        (op),
  .rep       (rep),
  .result    (result),
  .ovf       (ovf),
  .car_top   (car_top),
  .car_below (car_below)
);

// File: tb/multirep_addsub_tb.sv
`timescale 1ns/1ps
module multirep_addsub_tb;
  localparam int W = 4;
  localparam int N = 1 << W;
  localparam int H = 1 << (W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0] op_a, op_b, result;
  logic [1:0]   op, rep;
  logic         ovf;

  multirep_addsub #(.W(W)) u_dut (
    .op_a(op_a), .op_b(op_b), .op(op), .rep(rep),
    .result(result), .ovf(ovf)
  );

  typedef struct {
    logic [W-1:0] res;
    logic         flag;
    string        tag;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic int wrapn(int t);
    return ((t % N) + N) % N;
  endfunction

  function automatic int ones_val(int v);
    return (v >= H) ? v - (N - 1) : v;
  endfunction

  function automatic exp_t model(int r, int o, int a, int b);
    exp_t e;
    int t, va, vb, aa, bb, raw, sa, sb, ma, mb;
    bit neg, sub;
    neg = (o == 2);
    sub = (o == 1);
    e.flag = 1'b0;
    e.tag = "R1";
    case (r)
      0: begin
        t = neg ? -a : (sub ? a - b : a + b);
        e.res = W'(wrapn(t));
        e.flag = (t < 0) || (t >= N);
        e.tag = neg ? "R13" : (sub ? "R2" : "R1");
      end
      3: begin
        va = (a >= H) ? a - N : a;
        vb = (b >= H) ? b - N : b;
        t = neg ? -va : (sub ? va - vb : va + vb);
        e.res = W'(wrapn(t));
        e.flag = (t < -H) || (t >= H);
        e.tag = neg ? "R4" : "R3";
      end
      2: begin
        aa = neg ? 0 : a;
        bb = neg ? (~a & (N - 1)) : (sub ? (~b & (N - 1)) : b);
        raw = aa + bb;
        e.res = W'((raw >= N) ? raw - N + 1 : raw);
        t = ones_val(aa) + ones_val(bb);
        e.flag = (t > H - 1) || (t < -(H - 1));
        e.tag = neg ? "R7" : (sub ? "R6" : (raw >= N ? "R5" : "R6"));
      end
      default: begin
        if (neg) begin
          e.res = W'(a ^ H);
          e.tag = "R11";
        end else begin
          sa = a / H; ma = a % H;
          sb = (b / H) ^ (sub ? 1 : 0); mb = b % H;
          if (sa == sb) begin
            t = ma + mb;
            e.flag = (t >= H);
            e.res = W'(sa * H + (t % H));
            e.tag = sub ? "R10" : "R8";
          end else begin
            if (ma > mb)      e.res = W'(sa * H + ma - mb);
            else if (mb > ma) e.res = W'(sb * H + mb - ma);
            else              e.res = '0;
            e.tag = sub ? "R10" : "R9";
          end
        end
      end
    endcase
    if (o == 3) e.tag = "R12";
    if (neg && b != 0) e.tag = "R13";
    return e;
  endfunction

  task automatic drive(int r, int o, int a, int b);
    @(posedge clk);
    rep  = 2'(r);
    op   = 2'(o);
    op_a = W'(a);
    op_b = W'(b);
    sb_q.push_back(model(r, o, a, b));
  endtask

  // monitor: compare away from the driving edge
  always @(negedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (result !== e.res || ovf !== e.flag) begin
        n_fail++;
        $display("FAIL %s rep=%0d op=%0d a=%0h b=%0h: got res=%0h ovf=%0b, exp res=%0h ovf=%0b",
                 e.tag, rep, op, op_a, op_b, result, ovf, e.res, e.flag);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    op_a = '0; op_b = '0; op = 2'd0; rep = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset-time state: all-zero inputs give zero, no flag (R1)
    n_chk++;
    if (result !== '0 || ovf !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle: got res=%0h ovf=%0b, exp res=0 ovf=0", result, ovf);
    end
    rst = 1'b0;
    for (int r = 0; r < 4; r++)
      for (int o = 0; o < 4; o++)
        for (int a = 0; a < N; a++)
          for (int b = 0; b < N; b++)
            drive(r, o, a, b);
    repeat (3) @(posedge clk);
    done = 1;
    finish_run();
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      finish_run();
    end
  end
endmodule